// File: doc/BRIEF.md
# Indirect Address-Data Register Bridge

This block opens an internal 16-bit register space to a host through three 32-bit window registers. The address register is at byte offset 0x0, the data register at 0x4 and the control register at 0x8. The host first places an internal address in the address register. It then accesses the data register, and the bridge turns each data access into a request on an internal valid/ready register bus. That bus has a one-cycle read latency. A small register file sits on the internal bus as the target.

An address only takes effect after the host writes the same value twice in a row. Reads are pipelined. Each data-register read returns the result of the most recent completed internal fetch and at the same time launches a new fetch at the committed address. The host therefore reads the data register twice and keeps the second result. A single data-register write updates the target.

Bit 15 of the control register turns on bus-error reporting for internal addresses that the register file does not map.

Top module: `idxb_top`

## Requirements
- R1: After reset no response is pending. The address register and control register read 0, and the first data-register read returns 0 with no error.
- R2: Every host request, read or write to any offset, produces exactly one response, valid in the second cycle after the request cycle. Write responses carry zero read data.
- R3: An address-register write uses only bits 15:0 of the write data. Reading the address register returns the committed address, zero-extended.
- R4: An address is committed only by two consecutive address-register writes with equal low 16 bits. A single write, or a write that differs from the armed value, leaves the committed address unchanged. A differing write re-arms the sequence with its own value.
- R5: Any other host access between two address-register writes breaks the commit sequence.
- R6: One data-register write stores the write data into the target register at the committed address. Mapped addresses are 0 to DEPTH-1.
- R7: A data-register read returns the value and error flag of the most recent completed fetch, and launches a fetch of the committed address. The second of two consecutive data reads, whether back-to-back or one idle cycle apart, returns the register at the committed address. An unmapped address fetches 0.
- R8: An address-register write issued in the cycle after a data read cancels that read's fetch. The next data read then still returns the value held before that fetch.
- R9: With control bit 15 set, the response to a data write to an unmapped address has its error flag set. So does a data read returning a fetch from an unmapped address. With the bit clear, no response has the error flag set.
- R10: The control register keeps only bit 15. It reads back as 0x00008000 or 0.
- R11: Accesses to any offset other than 0x0, 0x4 and 0x8 read 0 and change no state.
- R12: An internal request is raised only for a data-register access. The target accepts it in the same cycle and answers in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host request strobe, one per cycle |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_ofs | input | 4 | Byte offset within the window |
| hst_wdata | input | 32 | Host write data |
| hst_rsp_valid | output | 1 | Response valid, two cycles after the request |
| hst_rsp_rdata | output | 32 | Response read data |
| hst_rsp_err | output | 1 | Response bus error |

## Verification
A request is registered at the first edge and its response is formed at the second edge. The response is valid in the cycle that follows. The bench therefore drives each request at a falling edge and samples its response two falling edges later. Between the two it checks that no response is present.

A fetch launched by a data read is answered by the target one cycle after launch. A data read issued in the very next cycle must still see that fetch. Back-to-back pairs are driven to cover this case and the case where an address write cancels a fetch in flight. Expected values come from a model in the bench of the register contents and of the value last fetched.

// File: rtl/idxb_pkg.sv
package idxb_pkg;
    localparam int HW  = 32;
    localparam int IAW = 16;
    localparam int OW  = 4;
    localparam logic [OW-1:0] OFS_ADDR = 4'h0;
    localparam logic [OW-1:0] OFS_DATA = 4'h4;
    localparam logic [OW-1:0] OFS_CTRL = 4'h8;
    localparam int ERR_EN_BIT = 15;

    typedef enum logic [1:0] {WIN_ADDR, WIN_DATA, WIN_CTRL, WIN_NONE} win_e;

    typedef struct packed {
        logic          valid;
        logic          we;
        win_e          win;
        logic [HW-1:0] wdata;
    } hreq_t;

    typedef struct packed {
        logic           valid;
        logic           we;
        logic [IAW-1:0] addr;
        logic [HW-1:0]  wdata;
    } ireq_t;

    typedef struct packed {
        logic          valid;
        logic          err;
        logic [HW-1:0] rdata;
    } irsp_t;

    function automatic win_e decode_ofs(input logic [OW-1:0] ofs);
        case (ofs)
            OFS_ADDR: return WIN_ADDR;
            OFS_DATA: return WIN_DATA;
            OFS_CTRL: return WIN_CTRL;
            default:  return WIN_NONE;
        endcase
    endfunction
endpackage

// File: rtl/idxb_regfile.sv
module idxb_regfile
    import idxb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  ireq_t req,
    output logic  ready,
    output irsp_t rsp
);
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [HW-1:0] regs [DEPTH];
    logic          mapped;
    logic [IDXW-1:0] idx;

    assign ready  = 1'b1;
    assign mapped = (32'(req.addr) < DEPTH);
    assign idx    = req.addr[IDXW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else begin
            rsp.valid <= req.valid;
            rsp.err   <= req.valid && !mapped;
            rsp.rdata <= (req.valid && !req.we && mapped) ? regs[idx] : '0;
            if (req.valid && req.we && mapped) regs[idx] <= req.wdata;
        end
    end
endmodule

// File: rtl/idxb_addr_commit.sv
module idxb_addr_commit
    import idxb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic           other,
    input  logic [IAW-1:0] wval,
    output logic [IAW-1:0] commit_addr
);
    logic [IAW-1:0] first_q;
    logic           armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q     <= '0;
            armed_q     <= 1'b0;
            commit_addr <= '0;
        end else if (wr) begin
            if (armed_q && first_q == wval) begin
                commit_addr <= wval;
                armed_q     <= 1'b0;
            end else begin
                first_q <= wval;
                armed_q <= 1'b1;
            end
        end else if (other) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/idxb_core.sv
module idxb_core
    import idxb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  hreq_t          s1,
    input  logic [IAW-1:0] commit_addr,
    output ireq_t          ireq,
    input  irsp_t          irsp,
    output logic           err_en,
    output logic           rsp_valid,
    output logic [HW-1:0]  rsp_rdata,
    output logic           rsp_err
);
    logic [HW-1:0] hold_q, hold_now, rd_c;
    logic          hold_err_q, hold_err_now, err_c;
    logic          pend_q;
    logic          s2_valid, s2_wdata, s2_en, s2_err;
    logic          launch, addr_wr, take;

    assign ireq.valid = s1.valid && s1.win == WIN_DATA;
    assign ireq.we    = s1.we;
    assign ireq.addr  = commit_addr;
    assign ireq.wdata = s1.wdata;

    assign launch  = s1.valid && s1.win == WIN_DATA && !s1.we;
    assign addr_wr = s1.valid && s1.win == WIN_ADDR && s1.we;
    assign take    = irsp.valid && pend_q && !addr_wr;

    assign hold_now     = take ? irsp.rdata : hold_q;
    assign hold_err_now = take ? irsp.err : hold_err_q;

    always_comb begin
        rd_c  = '0;
        err_c = 1'b0;
        if (!s1.we) begin
            case (s1.win)
                WIN_ADDR: rd_c = HW'(commit_addr);
                WIN_DATA: begin
                    rd_c  = hold_now;
                    err_c = hold_err_now && err_en;
                end
                WIN_CTRL: rd_c = HW'(err_en) << ERR_EN_BIT;
                default:  rd_c = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= '0;
            hold_err_q <= 1'b0;
            pend_q     <= 1'b0;
            err_en     <= 1'b0;
            s2_valid   <= 1'b0;
            s2_wdata   <= 1'b0;
            s2_en      <= 1'b0;
            s2_err     <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            if (take) begin
                hold_q     <= irsp.rdata;
                hold_err_q <= irsp.err;
            end
            if (addr_wr)     pend_q <= 1'b0;
            else if (launch) pend_q <= 1'b1;
            else if (take)   pend_q <= 1'b0;
            if (s1.valid && s1.we && s1.win == WIN_CTRL)
                err_en <= s1.wdata[ERR_EN_BIT];
            s2_valid  <= s1.valid;
            s2_wdata  <= s1.valid && s1.we && s1.win == WIN_DATA;
            s2_en     <= err_en;
            s2_err    <= s1.valid && err_c;
            rsp_rdata <= s1.valid ? rd_c : '0;
        end
    end

    assign rsp_valid = s2_valid;
    assign rsp_err   = s2_wdata ? (irsp.valid && irsp.err && s2_en) : s2_err;
endmodule

// File: rtl/idxb_top.sv
module idxb_top
    import idxb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hst_req,
    input  logic          hst_we,
    input  logic [OW-1:0] hst_ofs,
    input  logic [HW-1:0] hst_wdata,
    output logic          hst_rsp_valid,
    output logic [HW-1:0] hst_rsp_rdata,
    output logic          hst_rsp_err
);
    hreq_t          s1;
    ireq_t          ireq;
    irsp_t          irsp;
    logic           ib_ready;
    logic [IAW-1:0] commit_addr;
    logic           err_en;
    logic           s1_addr_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= hst_req;
            s1.we    <= hst_we;
            s1.win   <= decode_ofs(hst_ofs);
            s1.wdata <= hst_wdata;
        end
    end

    assign s1_addr_wr = s1.valid && s1.we && s1.win == WIN_ADDR;

    idxb_addr_commit u_commit (
        .clk         (clk),
        .rst         (rst),
        .wr          (s1_addr_wr),
        .other       (s1.valid && !s1_addr_wr),
        .wval        (s1.wdata[IAW-1:0]),
        .commit_addr (commit_addr)
    );

    idxb_core u_core (
        .clk         (clk),
        .rst         (rst),
        .s1          (s1),
        .commit_addr (commit_addr),
        .ireq        (ireq),
        .irsp        (irsp),
        .err_en      (err_en),
        .rsp_valid   (hst_rsp_valid),
        .rsp_rdata   (hst_rsp_rdata),
        .rsp_err     (hst_rsp_err)
    );

    idxb_regfile #(.DEPTH(DEPTH)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .req   (ireq),
        .ready (ib_ready),
        .rsp   (irsp)
    );
endmodule

// File: rtl/idxb_chk.sv
module idxb_chk
    import idxb_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           hst_req,
    input logic           hst_rsp_valid,
    input logic           hst_rsp_err,
    input logic           ib_valid,
    input logic           ib_ready,
    input logic           ib_rsp_valid,
    input logic [IAW-1:0] commit_addr,
    input logic           s1_addr_wr,
    input logic           err_en
);
    assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (rst)
        hst_req |-> ##2 hst_rsp_valid);

    assert_ib_accept_R12: assert property (@(posedge clk) disable iff (rst)
        ib_valid |-> ib_ready);

    assert_ib_answer_R12: assert property (@(posedge clk) disable iff (rst)
        ib_valid |=> ib_rsp_valid);

    assert_ib_from_host_R12: assert property (@(posedge clk) disable iff (rst)
        ib_valid |-> $past(hst_req));

    assert_commit_cause_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(commit_addr) |-> $past(s1_addr_wr));

    assert_err_gated_R9: assert property (@(posedge clk) disable iff (rst)
        hst_rsp_err |-> (err_en && hst_rsp_valid));
endmodule

bind idxb_top idxb_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .hst_req       (hst_req),
    .hst_rsp_valid (hst_rsp_valid),
    .hst_rsp_err   (hst_rsp_err),
    .ib_valid      (ireq.valid),
    .ib_ready      (ib_ready),
    .ib_rsp_valid  (irsp.valid),
    .commit_addr   (commit_addr),
    .s1_addr_wr    (s1_addr_wr),
    .err_en        (err_en)
);

// File: tb/sim_idxb_top.sv
module sim_idxb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int NADDR = DEPTH + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_req = 1'b0;
    logic        hst_we = 1'b0;
    logic [3:0]  hst_ofs = '0;
    logic [31:0] hst_wdata = '0;
    logic        hst_rsp_valid;
    logic [31:0] hst_rsp_rdata;
    logic        hst_rsp_err;

    int nchk = 0;
    int nfail = 0;

    logic [31:0] mdl [NADDR];
    logic [31:0] exp_hold;
    logic        exp_herr;
    logic        en_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    idxb_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .hst_req(hst_req), .hst_we(hst_we),
        .hst_ofs(hst_ofs), .hst_wdata(hst_wdata),
        .hst_rsp_valid(hst_rsp_valid), .hst_rsp_rdata(hst_rsp_rdata),
        .hst_rsp_err(hst_rsp_err)
    );

    function automatic logic [31:0] pat(input int a, input int salt);
        return 32'h5A00_0000 + 32'(a) * 32'h0001_0203 + 32'(salt) * 32'h0100_0000;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [3:0] ofs, input logic [31:0] wd,
                       output logic [31:0] rd, output logic er);
        hst_req = 1'b1; hst_we = we; hst_ofs = ofs; hst_wdata = wd;
        @(negedge clk);
        hst_req = 1'b0;
        check("R2 no early response", 32'(hst_rsp_valid), 32'd0);
        @(negedge clk);
        check("R2 response due", 32'(hst_rsp_valid), 32'd1);
        rd = hst_rsp_rdata; er = hst_rsp_err;
    endtask

    task automatic pair(input logic we0, input logic [3:0] of0, input logic [31:0] wd0,
                        input logic we1, input logic [3:0] of1, input logic [31:0] wd1,
                        output logic [31:0] rd0, output logic er0,
                        output logic [31:0] rd1, output logic er1);
        hst_req = 1'b1; hst_we = we0; hst_ofs = of0; hst_wdata = wd0;
        @(negedge clk);
        hst_we = we1; hst_ofs = of1; hst_wdata = wd1;
        @(negedge clk);
        hst_req = 1'b0;
        check("R2 pair first", 32'(hst_rsp_valid), 32'd1);
        rd0 = hst_rsp_rdata; er0 = hst_rsp_err;
        @(negedge clk);
        check("R2 pair second", 32'(hst_rsp_valid), 32'd1);
        rd1 = hst_rsp_rdata; er1 = hst_rsp_err;
    endtask

    task automatic commit(input int a);
        logic [31:0] r; logic e;
        acc(1'b1, 4'h0, 32'(a), r, e);
        acc(1'b1, 4'h0, 32'(a), r, e);
    endtask

    task automatic dread(input string tag, input int a);
        logic [31:0] r; logic e;
        acc(1'b0, 4'h4, '0, r, e);
        check({tag, " data"}, r, exp_hold);
        check({tag, " err"}, 32'(e), 32'(exp_herr && en_m));
        exp_hold = (a < DEPTH) ? mdl[a] : '0;
        exp_herr = (a >= DEPTH);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] r, r1;
        logic e, e1;
        for (int i = 0; i < NADDR; i++) mdl[i] = '0;
        exp_hold = '0; exp_herr = 1'b0; en_m = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 no response", 32'(hst_rsp_valid), 32'd0);
        acc(1'b0, 4'h0, '0, r, e); check("R1 addr reg", r, 32'd0);
        acc(1'b0, 4'h8, '0, r, e); check("R1 ctrl reg", r, 32'd0);
        acc(1'b0, 4'h4, '0, r, e); check("R1 data read", r, 32'd0);
        check("R1 data err", 32'(e), 32'd0);
        exp_hold = '0; exp_herr = 1'b0;

        // R6 sweep writes, including unmapped addresses
        for (int a = 0; a < NADDR; a++) begin
            commit(a);
            acc(1'b1, 4'h4, pat(a, 0), r, e);
            check("R6 write resp data", r, 32'd0);
            check("R9 no err while disabled", 32'(e), 32'd0);
            if (a < DEPTH) mdl[a] = pat(a, 0);
        end
        // R7 sweep double reads
        for (int a = NADDR - 1; a >= 0; a--) begin
            commit(a);
            dread("R7 first read", a);
            dread("R7 second read", a);
        end
        // R7 back-to-back reads
        for (int a = 0; a < DEPTH; a += 3) begin
            commit(a);
            pair(1'b0, 4'h4, '0, 1'b0, 4'h4, '0, r, e, r1, e1);
            check("R7 b2b first", r, exp_hold);
            check("R7 b2b second", r1, mdl[a]);
            exp_hold = mdl[a]; exp_herr = 1'b0;
        end

        // R3 low 16 bits
        acc(1'b1, 4'h0, 32'hABCD_0003, r, e);
        acc(1'b1, 4'h0, 32'h1234_0003, r, e);
        acc(1'b0, 4'h0, '0, r, e); check("R3 addr low bits", r, 32'd3);
        // R4 single and mismatch
        commit(5);
        acc(1'b1, 4'h0, 32'd2, r, e);
        acc(1'b0, 4'h0, '0, r, e); check("R4 single write", r, 32'd5);
        acc(1'b1, 4'h0, 32'd6, r, e);
        acc(1'b1, 4'h0, 32'd7, r, e);
        acc(1'b0, 4'h0, '0, r, e); check("R4 mismatch", r, 32'd5);
        acc(1'b1, 4'h0, 32'd6, r, e);
        acc(1'b1, 4'h0, 32'd7, r, e);
        acc(1'b1, 4'h0, 32'd7, r, e);
        acc(1'b0, 4'h0, '0, r, e); check("R4 restart latest", r, 32'd7);
        // R5 interrupted sequence
        acc(1'b1, 4'h0, 32'd2, r, e);
        acc(1'b0, 4'h8, '0, r, e);
        acc(1'b1, 4'h0, 32'd2, r, e);
        acc(1'b0, 4'h0, '0, r, e); check("R5 broken sequence", r, 32'd7);

        // R10 control register
        acc(1'b1, 4'h8, 32'hFFFF_FFFF, r, e);
        acc(1'b0, 4'h8, '0, r, e); check("R10 ctrl only bit 15", r, 32'h0000_8000);
        en_m = 1'b1;
        // R9 errors enabled
        commit(DEPTH);
        acc(1'b1, 4'h4, 32'h1111_1111, r, e); check("R9 unmapped write err", 32'(e), 32'd1);
        dread("R9 unmapped first", DEPTH);
        dread("R9 unmapped second", DEPTH);
        commit(1);
        acc(1'b1, 4'h4, pat(1, 5), r, e); check("R9 mapped write no err", 32'(e), 32'd0);
        mdl[1] = pat(1, 5);
        dread("R9 read after unmapped", 1);
        dread("R9 mapped second", 1);
        acc(1'b1, 4'h8, 32'h0, r, e);
        acc(1'b0, 4'h8, '0, r, e); check("R10 ctrl cleared", r, 32'd0);
        en_m = 1'b0;

        // R8 cancel
        commit(1);
        dread("R8 setup", 1);
        dread("R8 setup", 1);
        commit(2);
        pair(1'b0, 4'h4, '0, 1'b1, 4'h0, 32'd3, r, e, r1, e1);
        check("R8 launch read", r, mdl[1]);
        dread("R8 after cancel", 2);
        check("R8 cancelled holding", exp_hold, mdl[2]);
        dread("R8 refetch", 2);

        // R11 unused offset
        acc(1'b1, 4'hC, 32'hFFFF_FFFF, r, e);
        acc(1'b0, 4'hC, '0, r, e); check("R11 unused reads 0", r, 32'd0);
        acc(1'b0, 4'h8, '0, r, e); check("R11 ctrl unchanged", r, 32'd0);
        acc(1'b0, 4'h0, '0, r, e); check("R11 addr unchanged", r, 32'd2);
        // R12 data path still intact after all
        dread("R12 read", 2);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule